// File: doc/BRIEF.md
# Decode Slot Template Allocator

This block sits between instruction length marking and the decoders of a wide front end. Each cycle it sees a group of up to four instructions in program order. Each instruction has a 3-bit field that says how many micro-operations it expands into. The block maps the group onto four decode slots that are not alike. The first slot accepts an instruction of up to four micro-operations. The other three slots accept only single micro-operation instructions.

Allocation walks the group from oldest to youngest and stops at the first instruction that cannot take its slot. That instruction and every younger one are left in place, so the stopping instruction leads the next group. An instruction longer than four micro-operations is not decoded directly. When it reaches the first slot, it is handed to a microcode sequencer. The sequencer then stalls the allocator and reports four micro-operations per cycle until its done input releases it.

All allocation outputs are combinational from the current group and the sequencer state. Only the sequencer busy flag is registered.

Top module: `uop_slot_alloc`

## Requirements
- R1: When lane 0 holds count 0 (no instruction), no slot issues and the consumed count is 0.
- R2: With the sequencer idle, a lane 0 count of 1 to 4 issues slot 0 (issue bit 0 set).
- R3: A lane from 1 to 3 issues only if every older lane issued and its own count is exactly 1. A count of 2 to 7 stops allocation at that lane, and no younger lane issues.
- R4: A count of 0 in any lane ends the group. That lane and all younger lanes do not issue.
- R5: The issue mask is always an oldest-first contiguous prefix (bit i means lane i). The consumed count, from 0 to 4, equals the number of issued lanes plus one when lane 0 goes to the sequencer.
- R6: With the sequencer idle, a lane 0 count of 5 to 7 raises the handoff output for that cycle. In that cycle the consumed count is 1, the issue mask is 0, and no younger lane issues.
- R7: From the cycle after a handoff, busy is high and stays high through the cycle in which done is seen. While busy, the issue mask and the consumed count are 0 and the sequencer micro-operation output reads 4. In all other cycles that output reads 0.
- R8: A done pulse while the sequencer is idle has no effect: busy stays low and allocation proceeds normally.
- R9: After reset the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| grp_cnt | input | 12 | Micro-op counts, lane i at bits [3i+2:3i]; lane 0 is the oldest |
| mseq_done | input | 1 | Microcode sequencer finished its flow |
| issue_mask | output | 4 | Lanes issued to the direct decoders this cycle |
| consumed | output | 3 | Instructions taken from the group this cycle |
| mseq_start | output | 1 | Lane 0 handed to the microcode sequencer |
| mseq_busy | output | 1 | Sequencer active; allocator stalled |
| mseq_uops | output | 3 | Micro-ops emitted by the sequencer this cycle |

## Verification
The properties watch several things on every cycle. The issue mask must stay a contiguous prefix, and the consumed count must match it. A younger slot may never issue a multi-micro-operation instruction. Slot 0 may never directly issue a long one. The allocator must stay silent while busy, and a handoff must set busy. Done must release busy, and an idle done must change nothing. Only the directed scenarios show the exact stopping point for particular count patterns and the length of a stall held by a late done.

// File: rtl/uop_alloc_pkg.sv
package uop_alloc_pkg;
   localparam int unsigned LANES      = 4;
   localparam int unsigned CNT_W      = 3;
   localparam int unsigned WIDE_MAX   = 4;
   localparam int unsigned NARROW_MAX = 1;
   localparam int unsigned MS_RATE    = 4;
   localparam int unsigned CONS_W     = $clog2(LANES + 1);

   typedef enum logic {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_state_e;
endpackage

// File: rtl/uop_lane_fit.sv
module uop_lane_fit #(
   parameter int unsigned SLOT     = 0,
   parameter int unsigned CNT_W    = 3,
   parameter int unsigned WIDE_MAX = 4,
   parameter int unsigned NARROW_MAX = 1
) (
   input  logic [CNT_W-1:0] cnt,
   output logic             fits,
   output logic             too_long
);
   localparam int unsigned CAP = (SLOT == 0) ? WIDE_MAX : NARROW_MAX;

   generate
      if (CAP >= (1 << CNT_W)) begin : g_bad_cap
         $error("slot capacity exceeds count field range");
      end
      if (SLOT == 0) begin : g_wide
         assign fits     = (cnt != '0) && (32'(cnt) <= CAP);
         assign too_long = 32'(cnt) > CAP;
      end else begin : g_narrow
         assign fits     = (cnt != '0) && (32'(cnt) <= CAP);
         assign too_long = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/uop_mseq_ctrl.sv
module uop_mseq_ctrl
   import uop_alloc_pkg::*;
#(
   parameter int unsigned CNT_W   = 3,
   parameter int unsigned MS_RATE = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             done,
   output logic             busy,
   output logic [CNT_W-1:0] uops
);
   seq_state_e st_q;

   generate
      if (MS_RATE >= (1 << CNT_W)) begin : g_bad_rate
         $error("sequencer rate does not fit the count width");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      st_q <= SEQ_IDLE;
      else if (st_q == SEQ_IDLE && start) st_q <= SEQ_RUN;
      else if (st_q == SEQ_RUN && done)   st_q <= SEQ_IDLE;
   end

   assign busy = (st_q == SEQ_RUN);
   assign uops = busy ? CNT_W'(MS_RATE) : '0;
endmodule

// File: rtl/uop_slot_alloc.sv
module uop_slot_alloc
   import uop_alloc_pkg::*;
(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [LANES*CNT_W-1:0] grp_cnt,
   input  logic                   mseq_done,
   output logic [LANES-1:0]       issue_mask,
   output logic [CONS_W-1:0]      consumed,
   output logic                   mseq_start,
   output logic                   mseq_busy,
   output logic [CNT_W-1:0]       mseq_uops
);
   logic [LANES-1:0] fit;
   logic [LANES-1:0] long_l;

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("at least one lane required");
      end
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         uop_lane_fit #(
            .SLOT(i), .CNT_W(CNT_W), .WIDE_MAX(WIDE_MAX), .NARROW_MAX(NARROW_MAX)
         ) u_fit (
            .cnt      (grp_cnt[i*CNT_W +: CNT_W]),
            .fits     (fit[i]),
            .too_long (long_l[i])
         );
      end
   endgenerate

   always_comb begin
      logic go;
      go = ~mseq_busy;
      mseq_start = go & long_l[0];
      for (int i = 0; i < LANES; i++) begin
         issue_mask[i] = go & fit[i];
         go            = issue_mask[i];
      end
   end

   always_comb begin
      consumed = CONS_W'(mseq_start);
      for (int i = 0; i < LANES; i++)
         consumed = consumed + CONS_W'(issue_mask[i]);
   end

   uop_mseq_ctrl #(.CNT_W(CNT_W), .MS_RATE(MS_RATE)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (mseq_start),
      .done  (mseq_done),
      .busy  (mseq_busy),
      .uops  (mseq_uops)
   );
endmodule

// File: rtl/uop_slot_alloc_chk.sv
module uop_slot_alloc_chk
   import uop_alloc_pkg::*;
(
   input logic                   clk,
   input logic                   rst_n,
   input logic [LANES*CNT_W-1:0] grp_cnt,
   input logic                   mseq_done,
   input logic [LANES-1:0]       issue_mask,
   input logic [CONS_W-1:0]      consumed,
   input logic                   mseq_start,
   input logic                   mseq_busy,
   input logic [CNT_W-1:0]       mseq_uops
);
   logic prefix_ok;
   logic narrow_ok;
   always_comb begin
      prefix_ok = 1'b1;
      narrow_ok = 1'b1;
      for (int i = 1; i < LANES; i++) begin
         if (issue_mask[i] && !issue_mask[i-1]) prefix_ok = 1'b0;
         if (issue_mask[i] && grp_cnt[i*CNT_W +: CNT_W] != CNT_W'(1)) narrow_ok = 1'b0;
      end
   end

   p_prefix_r5: assert property (@(posedge clk) disable iff (!rst_n) prefix_ok);
   p_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
      32'(consumed) == $countones(issue_mask) + 32'(mseq_start));
   p_narrow_r3: assert property (@(posedge clk) disable iff (!rst_n) narrow_ok);
   p_wide_r2: assert property (@(posedge clk) disable iff (!rst_n)
      issue_mask[0] |-> (grp_cnt[CNT_W-1:0] != '0 && 32'(grp_cnt[CNT_W-1:0]) <= WIDE_MAX));
   p_handoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mseq_start |-> (issue_mask == '0 && consumed == CONS_W'(1)));
   p_busy_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mseq_start |=> mseq_busy);
   p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mseq_busy |-> (issue_mask == '0 && consumed == '0 && !mseq_start));
   p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mseq_busy && mseq_done) |=> !mseq_busy);
   p_idle_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!mseq_busy && !mseq_start) |=> !mseq_busy);
endmodule

bind uop_slot_alloc uop_slot_alloc_chk u_chk (.*);

// File: tb/uop_slot_alloc_bench.sv
module uop_slot_alloc_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] grp_cnt = '0;
   logic        mseq_done = 1'b0;
   logic [3:0]  issue_mask;
   logic [2:0]  consumed;
   logic        mseq_start;
   logic        mseq_busy;
   logic [2:0]  mseq_uops;
   int          n_run = 0;
   int          n_fail = 0;
   bit          finished = 1'b0;

   always #2 clk = ~clk;

   uop_slot_alloc u_uop_slot_alloc (.*);

   function automatic logic [11:0] grp(input int l3, l2, l1, l0);
      return {3'(l3), 3'(l2), 3'(l1), 3'(l0)};
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic apply_and_check(input string req, input logic [11:0] g,
                                  input int mask, input int cons, input int start);
      @(negedge clk);
      grp_cnt = g;
      #1;
      check({req, " mask"}, int'(issue_mask), mask);
      check({req, " consumed"}, int'(consumed), cons);
      check({req, " start"}, int'(mseq_start), start);
   endtask

   task automatic t_reset;
      check("R9 busy after reset", int'(mseq_busy), 0);
      check("R9 uops after reset", int'(mseq_uops), 0);
   endtask

   task automatic t_direct;
      apply_and_check("R2 all single", grp(1,1,1,1), 4'hF, 4, 0);
      apply_and_check("R2 four-uop lead", grp(1,1,1,4), 4'hF, 4, 0);
      apply_and_check("R3 two-uop in lane2", grp(1,2,1,3), 4'h3, 2, 0);
      apply_and_check("R3 long in lane2", grp(1,7,1,1), 4'h3, 2, 0);
      apply_and_check("R3 two-uop lane1", grp(1,1,2,2), 4'h1, 1, 0);
      apply_and_check("R4 empty lane1", grp(1,1,0,2), 4'h1, 1, 0);
      apply_and_check("R4 empty lane3", grp(0,1,1,1), 4'h7, 3, 0);
      apply_and_check("R1 empty lane0", grp(1,1,1,0), 4'h0, 0, 0);
   endtask

   task automatic t_microcode;
      apply_and_check("R6 long lead", grp(1,1,1,6), 4'h0, 1, 1);
      @(negedge clk);
      grp_cnt = grp(1,1,1,1);
      #1;
      check("R7 busy after handoff", int'(mseq_busy), 1);
      check("R7 stall mask", int'(issue_mask), 0);
      check("R7 stall consumed", int'(consumed), 0);
      check("R7 seq uops", int'(mseq_uops), 4);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         #1;
         check("R7 still busy", int'(mseq_busy), 1);
      end
      @(negedge clk);
      mseq_done = 1'b1;
      #1;
      check("R7 busy in done cycle", int'(mseq_busy), 1);
      check("R7 no issue in done cycle", int'(issue_mask), 0);
      @(negedge clk);
      mseq_done = 1'b0;
      #1;
      check("R7 released", int'(mseq_busy), 0);
      check("R7 uops idle", int'(mseq_uops), 0);
      check("R7 resumed mask", int'(issue_mask), 4'hF);
   endtask

   task automatic t_idle_done;
      @(negedge clk);
      grp_cnt = grp(1,1,1,2);
      mseq_done = 1'b1;
      #1;
      check("R8 mask with idle done", int'(issue_mask), 4'hF);
      @(negedge clk);
      mseq_done = 1'b0;
      #1;
      check("R8 busy stays low", int'(mseq_busy), 0);
      check("R8 consumed", int'(consumed), 4);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      t_direct();
      t_microcode();
      t_idle_done();
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule